// File: doc/BRIEF.md
# Output-Stage Protection Sequencer

This block supervises a two-channel switching output stage. Each clock it samples four comparator flags: overcurrent, undervoltage, an over-temperature warning and an over-temperature error. It also samples an active-low control reset, a two-bit protection-mode select and the two PWM inputs. From these it produces one enable per half-bridge (high means driving, low means high impedance), a drive level per half-bridge, and two active-low status lines. Together the status lines tell a controller what went wrong.

Any error puts the block into a protection state that holds both channels in high impedance. In autorecovery mode the block leaves that state by itself. It counts rising edges of the channel-A PWM input: after half the recovery period the error latch is released, and after the full period switching resumes. In latched mode only a toggle of the control reset brings the outputs back.

The sequencer has five states:
- `ST_HOLD`: control reset low, outputs high impedance.
- `ST_RUN`: switching.
- `ST_LATCHED`: error held until the control reset is toggled.
- `ST_AR_LATCH`: autorecovery, latch set, first half of the period.
- `ST_AR_WAIT`: autorecovery, latch released, outputs still off.

Its transitions are:
- Reset drop: any state to `ST_HOLD`.
- Release: `ST_HOLD` to `ST_RUN`.
- Trip: `ST_RUN` to `ST_AR_LATCH` or `ST_LATCHED`, depending on the mode.
- Half-period: `ST_AR_LATCH` to `ST_AR_WAIT`.
- Resume: `ST_AR_WAIT` to `ST_RUN`.
- Re-trip: `ST_AR_WAIT` to `ST_AR_LATCH`.

Top module: `pwr_prot_ctrl`

## Requirements
- R1: An active overcurrent, undervoltage or over-temperature-error flag seen in `ST_RUN` drops `en_a` and `en_b` to 0 from the next clock edge, and `sd_n` goes to 0.
- R2: Mode select 2'b00 means autorecovery and 2'b01 means latched shutdown. The reserved values 2'b10 and 2'b11 behave exactly as latched shutdown.
- R3: In autorecovery, `sd_n` stays 0 for the first 255 counted PWM cycles after the trip and returns to 1 after cycle 256, with both enables still 0. The enables return to 1 after cycle 512.
- R4: In latched shutdown, the outputs stay disabled and `sd_n` stays 0 however long the flags stay clear and PWM keeps running. Driving `ctl_rst_n` low clears the latch, and driving it high again resumes switching on the next edge.
- R5: While `ctl_rst_n` is 0, both enables are 0 and `sd_n` is 1, even with a latched or live error.
- R6: The status pair {`otw_n`,`sd_n`} encodes the condition: 2'b00 for an over-temperature error, 2'b01 for a warning only, 2'b10 for an overcurrent or undervoltage error, 2'b11 for normal. A latched over-temperature cause takes precedence over the other causes.
- R7: The over-temperature warning on its own drives `otw_n` to 0 and leaves both enables at 1.
- R8: While enabled, `drv_a` equals `pwm_a` and `drv_b` equals `pwm_b`. So A-high/B-low drives A to supply and B to ground, the reverse pattern swaps them, and equal inputs (reserved) give equal levels.
- R9: Recovery cycles are counted only on rising edges of `pwm_a`, after a two-flop synchronizer. Activity on `pwm_b` alone does not advance the count.
- R10: If an error flag is still active when the 512-cycle period ends, the latch is set again (`sd_n`=0, enables 0) and a fresh period begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset for all registers |
| ctl_rst_n | input | 1 | Active-low control reset: disables outputs and clears the error latch |
| mode_sel | input | 2 | Protection mode: 00 autorecovery, 01 latched, 10/11 latched |
| pwm_a | input | 1 | PWM input for half-bridge A; its rising edges time recovery |
| pwm_b | input | 1 | PWM input for half-bridge B |
| flt_oc | input | 1 | Overcurrent flag, active high |
| flt_uv | input | 1 | Undervoltage flag, active high |
| flt_otw | input | 1 | Over-temperature warning flag, active high |
| flt_ote | input | 1 | Over-temperature error flag, active high |
| en_a | output | 1 | Half-bridge A enable; 0 means high impedance |
| en_b | output | 1 | Half-bridge B enable; 0 means high impedance |
| drv_a | output | 1 | Drive level for half-bridge A (1 supply, 0 ground) |
| drv_b | output | 1 | Drive level for half-bridge B |
| sd_n | output | 1 | Active-low shutdown status |
| otw_n | output | 1 | Active-low temperature status |

## Verification
The properties assume that `mode_sel` is static while the block is out of `ST_HOLD`. They also assume that the flags and `ctl_rst_n` are already synchronous to `clk`. The stimulus changes the mode only while `ctl_rst_n` is low, and it drives every input on the falling clock edge. Errors are injected only while `pwm_a` has been low for several clocks, so that no synchronized edge is in flight when a recovery period starts. That keeps the 256 and 512 cycle counts exact.

// File: rtl/prot_pkg.sv
package prot_pkg;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_RUN,
        ST_LATCHED,
        ST_AR_LATCH,
        ST_AR_WAIT
    } prot_state_e;

    localparam logic [1:0] MODE_AUTO = 2'b00;

endpackage

// File: rtl/prot_pwm_edge.sv
module prot_pwm_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    output logic rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pwm_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/prot_fsm.sv
module prot_fsm
    import prot_pkg::*;
#(
    parameter int AR_CYCLES = 512
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_rst_n,
    input  logic [1:0] mode_sel,
    input  logic       fault_any,
    input  logic       fault_ote,
    input  logic       cyc_pulse,
    output logic       run,
    output logic       latch_on,
    output logic       cause_ote
);

    localparam int CNT_W = $clog2(AR_CYCLES + 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(AR_CYCLES / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(AR_CYCLES - 1);

    prot_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cause_q, cause_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            cnt_q   <= '0;
            cause_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        cause_d = cause_q;
        if (!ctl_rst_n) begin
            state_d = ST_HOLD;
            cnt_d   = '0;
            cause_d = 1'b0;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = ST_RUN;
                ST_RUN: begin
                    if (fault_any) begin
                        cnt_d   = '0;
                        cause_d = fault_ote;
                        state_d = (mode_sel == MODE_AUTO) ? ST_AR_LATCH : ST_LATCHED;
                    end
                end
                ST_LATCHED: state_d = ST_LATCHED;
                ST_AR_LATCH: begin
                    if (cyc_pulse) begin
                        cnt_d = cnt_q + 1'b1;
                        if (cnt_q == HALF_LAST) state_d = ST_AR_WAIT;
                    end
                end
                ST_AR_WAIT: begin
                    if (cyc_pulse) begin
                        if (cnt_q == FULL_LAST) begin
                            cnt_d = '0;
                            if (fault_any) begin
                                state_d = ST_AR_LATCH;
                                cause_d = fault_ote;
                            end else begin
                                state_d = ST_RUN;
                                cause_d = 1'b0;
                            end
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: state_d = ST_HOLD;
            endcase
        end
    end

    always_comb begin
        run       = (state_q == ST_RUN);
        latch_on  = (state_q == ST_LATCHED) || (state_q == ST_AR_LATCH);
        cause_ote = cause_q;
    end

endmodule

// File: rtl/prot_status.sv
module prot_status (
    input  logic ctl_rst_n,
    input  logic run,
    input  logic latch_on,
    input  logic cause_ote,
    input  logic flt_otw,
    input  logic pwm_a,
    input  logic pwm_b,
    output logic en_a,
    output logic en_b,
    output logic drv_a,
    output logic drv_b,
    output logic sd_n,
    output logic otw_n
);

    always_comb begin
        en_a  = run & ctl_rst_n;
        en_b  = run & ctl_rst_n;
        drv_a = pwm_a;
        drv_b = pwm_b;
        sd_n  = ~(latch_on & ctl_rst_n);
        otw_n = ~((latch_on & cause_ote) | (~latch_on & flt_otw));
    end

endmodule

// File: rtl/pwr_prot_ctrl.sv
module pwr_prot_ctrl #(
    parameter int AR_CYCLES   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_rst_n,
    input  logic [1:0] mode_sel,
    input  logic       pwm_a,
    input  logic       pwm_b,
    input  logic       flt_oc,
    input  logic       flt_uv,
    input  logic       flt_otw,
    input  logic       flt_ote,
    output logic       en_a,
    output logic       en_b,
    output logic       drv_a,
    output logic       drv_b,
    output logic       sd_n,
    output logic       otw_n
);

    logic cyc_pulse;
    logic run;
    logic latch_on;
    logic cause_ote;
    logic fault_any;

    assign fault_any = flt_oc | flt_uv | flt_ote;

    prot_pwm_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_in (pwm_a),
        .rise   (cyc_pulse)
    );

    prot_fsm #(.AR_CYCLES(AR_CYCLES)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_rst_n (ctl_rst_n),
        .mode_sel  (mode_sel),
        .fault_any (fault_any),
        .fault_ote (flt_ote),
        .cyc_pulse (cyc_pulse),
        .run       (run),
        .latch_on  (latch_on),
        .cause_ote (cause_ote)
    );

    prot_status u_status (
        .ctl_rst_n (ctl_rst_n),
        .run       (run),
        .latch_on  (latch_on),
        .cause_ote (cause_ote),
        .flt_otw   (flt_otw),
        .pwm_a     (pwm_a),
        .pwm_b     (pwm_b),
        .en_a      (en_a),
        .en_b      (en_b),
        .drv_a     (drv_a),
        .drv_b     (drv_b),
        .sd_n      (sd_n),
        .otw_n     (otw_n)
    );

endmodule

// File: rtl/prot_ctrl_chk.sv
module prot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_rst_n,
    input logic [1:0] mode_sel,
    input logic       flt_oc,
    input logic       flt_uv,
    input logic       flt_ote,
    input logic       en_a,
    input logic       en_b,
    input logic       sd_n
);

    logic err;
    assign err = flt_oc | flt_uv | flt_ote;

    AST_FAULT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_n && en_a && err |=> !en_a && !en_b); // R1

    AST_RESET_HIZ_SD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rst_n |-> !en_a && !en_b && sd_n); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_n && (mode_sel != 2'b00) && !sd_n |=> !sd_n || !ctl_rst_n); // R4

    AST_RELEASE_OUTPUTS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_n) && ctl_rst_n && $past(ctl_rst_n) |-> !en_a && !en_b); // R3

    AST_CLEAN_RUN_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rst_n && en_a && !err |=> en_a || !ctl_rst_n); // R7

endmodule

bind pwr_prot_ctrl prot_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_rst_n (ctl_rst_n),
    .mode_sel  (mode_sel),
    .flt_oc    (flt_oc),
    .flt_uv    (flt_uv),
    .flt_ote   (flt_ote),
    .en_a      (en_a),
    .en_b      (en_b),
    .sd_n      (sd_n)
);

// File: tb/tb_pwr_prot_ctrl.sv
module tb_pwr_prot_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;
    localparam int NVEC       = 10;

    // {mode[1:0], pa, pb, oc, uv, otw, ote, exp{en_a,en_b,drv_a,drv_b,sd_n,otw_n}}
    localparam logic [13:0] VEC [NVEC] = '{
        {2'b01, 1'b1, 1'b0, 4'b0000, 6'b111011},  // R8 A high
        {2'b01, 1'b0, 1'b1, 4'b0000, 6'b110111},  // R8 B high
        {2'b01, 1'b1, 1'b1, 4'b0000, 6'b111111},  // R8 equal
        {2'b01, 1'b1, 1'b0, 4'b0010, 6'b111010},  // R7 warning only
        {2'b01, 1'b1, 1'b0, 4'b1000, 6'b001001},  // R6 overcurrent
        {2'b01, 1'b0, 1'b1, 4'b0100, 6'b000101},  // R6 undervoltage
        {2'b01, 1'b1, 1'b0, 4'b0001, 6'b001000},  // R6 ote
        {2'b11, 1'b1, 1'b0, 4'b1000, 6'b001001},  // R2 reserved 11
        {2'b10, 1'b0, 1'b1, 4'b0011, 6'b000100},  // R2 reserved 10
        {2'b00, 1'b1, 1'b0, 4'b1000, 6'b001001}   // R2 auto
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_rst_n = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic pwm_a = 1'b0, pwm_b = 1'b1;
    logic flt_oc = 1'b0, flt_uv = 1'b0, flt_otw = 1'b0, flt_ote = 1'b0;
    logic en_a, en_b, drv_a, drv_b, sd_n, otw_n;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_prot_ctrl dut (
        .clk(clk), .rst_n(rst_n), .ctl_rst_n(ctl_rst_n), .mode_sel(mode_sel),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .flt_oc(flt_oc), .flt_uv(flt_uv),
        .flt_otw(flt_otw), .flt_ote(flt_ote), .en_a(en_a), .en_b(en_b),
        .drv_a(drv_a), .drv_b(drv_b), .sd_n(sd_n), .otw_n(otw_n)
    );

    task automatic chk(input string req, input logic [5:0] exp);
        logic [5:0] act;
        act = {en_a, en_b, drv_a, drv_b, sd_n, otw_n};
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_bit(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pwm_cycle();
        pwm_a = 1'b1; pwm_b = 1'b0;
        clocks(4);
        pwm_a = 1'b0; pwm_b = 1'b1;
        clocks(4);
    endtask

    task automatic restart(input logic [1:0] m);
        ctl_rst_n = 1'b0;
        flt_oc = 0; flt_uv = 0; flt_otw = 0; flt_ote = 0;
        pwm_a = 1'b0; pwm_b = 1'b1;
        mode_sel = m;
        clocks(3);
        ctl_rst_n = 1'b1;
        clocks(3);
    endtask

    task automatic pulse_oc();
        flt_oc = 1'b1;
        clocks(1);
        flt_oc = 1'b0;
    endtask

    initial begin
        while (cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        n_err++;
        $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

    initial begin
        clocks(2);
        rst_n = 1'b1;
        clocks(2);
        // R5 reset state: control reset low
        chk("R5 reset state", 6'b000111);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            restart(VEC[v][13:12]);
            pwm_a = VEC[v][11]; pwm_b = VEC[v][10];
            clocks(1);
            {flt_oc, flt_uv, flt_otw, flt_ote} = VEC[v][9:6];
            clocks(2);
            chk($sformatf("R6/R8 vector %0d", v), VEC[v][5:0]);
            flt_oc = 0; flt_uv = 0; flt_otw = 0; flt_ote = 0;
        end

        // R1 next-edge shutdown timing
        restart(2'b01);
        flt_oc = 1'b1;
        @(posedge clk); #1;
        chk_bit("R1 en off after one edge", en_a, 1'b0);
        chk_bit("R1 sd low", sd_n, 1'b0);
        @(negedge clk);
        flt_oc = 1'b0;

        // R4 latched persists
        for (int i = 0; i < 20; i++) pwm_cycle();
        chk("R4 latched persists", 6'b000101);
        // R5 reset low forces sd high even with live error
        flt_oc = 1'b1;
        ctl_rst_n = 1'b0;
        #1;
        chk_bit("R5 sd high while reset low", sd_n, 1'b1);
        chk_bit("R5 outputs off while reset low", en_a | en_b, 1'b0);
        clocks(3);
        chk_bit("R5 sd high with live error", sd_n, 1'b1);
        flt_oc = 1'b0;
        clocks(1);
        ctl_rst_n = 1'b1;
        @(posedge clk); #1;
        chk_bit("R4 resume on reset rise", en_a & en_b, 1'b1);
        clocks(2);

        // R3/R9 autorecovery timing
        restart(2'b00);
        pulse_oc();
        clocks(3);
        for (int i = 0; i < 10; i++) begin
            pwm_b = 1'b0; clocks(4); pwm_b = 1'b1; clocks(4);
        end
        chk_bit("R9 pwm_b activity not counted", sd_n, 1'b0);
        for (int i = 0; i < 255; i++) pwm_cycle();
        chk_bit("R3 sd low at 255", sd_n, 1'b0);
        pwm_cycle();
        chk_bit("R3 latch clear at 256", sd_n, 1'b1);
        chk_bit("R3 still off at 256", en_a | en_b, 1'b0);
        for (int i = 0; i < 255; i++) pwm_cycle();
        chk_bit("R3 still off at 511", en_a | en_b, 1'b0);
        pwm_cycle();
        chk_bit("R3 resume at 512", en_a & en_b, 1'b1);

        // R10 persistent error re-trips
        restart(2'b00);
        flt_uv = 1'b1;
        clocks(2);
        for (int i = 0; i < 512; i++) pwm_cycle();
        chk("R10 re-trip with error active", 6'b000101);
        flt_uv = 1'b0;
        for (int i = 0; i < 511; i++) pwm_cycle();
        chk_bit("R10 new period not yet done", en_a, 1'b0);
        pwm_cycle();
        chk_bit("R10 resume after new period", en_a, 1'b1);

        // R5 reset during autorecovery
        pulse_oc();
        clocks(2);
        ctl_rst_n = 1'b0;
        clocks(2);
        chk("R5 reset during autorecovery", 6'b000111);
        ctl_rst_n = 1'b1;
        clocks(2);
        chk_bit("R4 clean restart", en_a, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    end

endmodule